// File: doc/BRIEF.md
# Vectored Interrupt Controller with Indirect Source Access

This block gathers up to 128 interrupt request lines and raises one processor interrupt line. Every source has its own enable bit, pending latch, mode word (a priority from 0 to 7 and a trigger type) and a vector word. Software does not see a flat array of per-source registers. It first writes a source index into the select register. The mode, vector, mask-status and command registers then act only on that source.

To service an interrupt, software reads the acknowledge register. The read returns the vector of the winning request. It also pushes that request's priority and source number onto a nesting stack, so that only a strictly higher priority can interrupt again. A write to the end-of-interrupt register pops the stack. When nothing is eligible, the acknowledge read returns a programmable spurious vector and leaves the stack as it is. A single-cycle synchronous register bus carries all accesses. Read data is registered. A write takes precedence over a read issued in the same cycle, and that read is dropped.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The select register at 0x00 holds the source index in bits [SRC_W-1:0] (7 bits for 128 sources). The mode register (0x04) and the vector register (0x08) write and read back only the currently selected source.
- R2: In the mode word, bits [2:0] are the priority (7 highest) and bits [6:5] the trigger type: 00 level-high, 01 rising edge, 10 level-low, 11 falling edge. All other bits are discarded on a write and read back as 0.
- R3: Any write to 0x40 enables the selected source, 0x44 disables it, 0x48 clears its pending latch and 0x4C sets it. Bit 0 of the mask-status register at 0x30 shows the selected source's enable bit. A disabled source never requests, but it keeps its pending latch.
- R4: An edge-type source sets its latch on the chosen edge, and the latch stays set after the line returns. A level-type source requests while its line is at the active level, without needing the latch.
- R5: Among enabled requesting sources, the one with the highest priority wins. On a tie, the lowest source index wins.
- R6: irq_out is high when a winner exists and either the stack is empty or the winner's priority is strictly greater than the priority on top of the stack.
- R7: A read of 0x10 while irq_out is high returns the winner's vector, pushes its priority and index, and clears its pending latch. The register at 0x18 returns the source on top of the stack, or 0 when the stack is empty.
- R8: A read of 0x10 while irq_out is low returns the spurious vector programmed at 0x3C and changes no state.
- R9: A write to 0x38 pops one stack entry, which uncovers the previous current source. The stack holds 8 levels, so 8 such writes always empty it. The same write on an empty stack has no effect.
- R10: Writes to 0x6C are accepted with no effect on any state, and the register reads 0.
- R11: Reset clears the selection, all enables, latches, modes, vectors, the stack and the spurious vector, and irq_out is low.
- R12: rd_data takes the addressed value on the clock edge that samples rd_en, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; ignored when wr_en is high |
| rd_data | output | DATA_W | Registered read data |
| irq_src | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| irq_out | output | 1 | Processor interrupt line |

## Verification
The bench uses 16 sources and drives the arbiter with twelve pending-set patterns. Each pattern is drained one acknowledge at a time against a winner computed in the bench. This separates priority order, tie-breaking by low index, and the clearing of the latch on acknowledge. A nesting sequence with equal, higher and lower priorities checks that the comparison with the stack top is strict and that pops restore the earlier current sources. The full eight-level stack is then unwound with one extra end-of-interrupt write. Each of the four trigger types is driven on a real line, which shows latch-and-hold behaviour apart from behaviour that follows the line level.

// File: rtl/ivc_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes byte offsets on an 8-bit address bus.
package ivc_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned PRIO_W   = 3;
    localparam int unsigned PRIO_LSB = 0;
    localparam int unsigned TRIG_LSB = 5;

    localparam logic [ADDR_W-1:0] OFS_SEL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CUR  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_SPUR = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_DIS  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_SET  = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_DBG  = 8'h6C;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'b00,
        TRIG_RISE   = 2'b01,
        TRIG_LVL_LO = 2'b10,
        TRIG_FALL   = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e             trig;
        logic [PRIO_W-1:0] prio;
    } src_mode_t;
endpackage

// File: rtl/ivc_src_bank.sv
// Per-source state: enable, pending latch, mode, vector and the previous
// line level used for edge detection. Writes and commands reach only the
// selected source. Assumes that irq_src is already synchronous to clk.
module ivc_src_bank
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SRC_W   = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_src,
    input  logic [SRC_W-1:0]           sel,
    input  logic                       mode_we,
    input  logic                       vec_we,
    input  logic                       ena_cmd,
    input  logic                       dis_cmd,
    input  logic                       clr_cmd,
    input  logic                       set_cmd,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       ack,
    input  logic [SRC_W-1:0]           ack_idx,
    input  logic [SRC_W-1:0]           win_idx,
    output src_mode_t                  sel_mode,
    output logic [DATA_W-1:0]          sel_vec,
    output logic                       sel_en,
    output logic [DATA_W-1:0]          win_vec,
    output logic [NUM_SRC-1:0]         req,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_flat
);
    localparam logic [SRC_W:0] NUM_SRC_L = (SRC_W+1)'(NUM_SRC);

    src_mode_t          mode_arr [NUM_SRC];
    logic [DATA_W-1:0]  vec_arr  [NUM_SRC];
    logic [NUM_SRC-1:0] en_vec;
    logic               sel_ok;
    logic               win_ok;

    assign sel_ok = {1'b0, sel} < NUM_SRC_L;
    assign win_ok = {1'b0, win_idx} < NUM_SRC_L;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic              hit_sel;
        logic              en_r;
        logic              lat_r;
        logic              prev_r;
        logic              edge_hit;
        logic              lvl_act;
        src_mode_t         mode_r;
        logic [DATA_W-1:0] vec_r;

        assign hit_sel = (sel == SRC_W'(i));

        // Decode the trigger type into an edge event and a level request.
        always_comb begin
            edge_hit = 1'b0;
            lvl_act  = 1'b0;
            case (mode_r.trig)
                TRIG_LVL_HI: lvl_act  = irq_src[i];
                TRIG_RISE:   edge_hit = irq_src[i] & ~prev_r;
                TRIG_LVL_LO: lvl_act  = ~irq_src[i];
                default:     edge_hit = ~irq_src[i] & prev_r;
            endcase
        end

        // Configuration words and the enable bit of this source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_r <= '0;
                vec_r  <= '0;
                en_r   <= 1'b0;
            end else if (hit_sel) begin
                if (mode_we) begin
                    mode_r <= '{trig: trig_e'(wdata[TRIG_LSB +: 2]),
                                prio: wdata[PRIO_LSB +: PRIO_W]};
                end
                if (vec_we) vec_r <= wdata;
                if (ena_cmd) en_r <= 1'b1;
                else if (dis_cmd) en_r <= 1'b0;
            end
        end

        // Pending latch: clear or acknowledge first, then set or edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_r  <= 1'b0;
                prev_r <= 1'b0;
            end else begin
                prev_r <= irq_src[i];
                lat_r  <= (lat_r & ~((clr_cmd & hit_sel) |
                                     (ack & (ack_idx == SRC_W'(i)))))
                          | (set_cmd & hit_sel) | edge_hit;
            end
        end

        assign req[i]                       = en_r & (lat_r | lvl_act);
        assign prio_flat[i*PRIO_W +: PRIO_W] = mode_r.prio;
        assign mode_arr[i]                  = mode_r;
        assign vec_arr[i]                   = vec_r;
        assign en_vec[i]                    = en_r;
    end

    assign sel_mode = sel_ok ? mode_arr[sel] : '0;
    assign sel_vec  = sel_ok ? vec_arr[sel]  : '0;
    assign sel_en   = sel_ok ? en_vec[sel]   : 1'b0;
    assign win_vec  = win_ok ? vec_arr[win_idx] : '0;
endmodule

// File: rtl/ivc_arbiter.sv
// Picks the requesting source with the highest priority. A strict
// comparison in an ascending scan lets the lowest index win a tie.
// Purely combinational.
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned SRC_W   = 7
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      win_valid,
    output logic [SRC_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Linear scan over all sources.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = SRC_W'(i);
                win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/ivc_nest_stack.sv
// LIFO of priority levels and source indices for nested service. A push
// on a full stack or a pop on an empty one is ignored. Assumes that push
// and pop never arrive in the same cycle.
module ivc_nest_stack
    import ivc_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned SRC_W = 7,
    parameter int unsigned CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [SRC_W-1:0]  push_src,
    input  logic              pop,
    output logic [CNT_W-1:0]  depth,
    output logic              empty,
    output logic [PRIO_W-1:0] top_prio,
    output logic [SRC_W-1:0]  top_src
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [SRC_W-1:0]  src_q  [DEPTH];
    logic [CNT_W-1:0]  depth_q;
    logic [CNT_W-1:0]  top_ptr;

    assign top_ptr  = depth_q - CNT_W'(1);
    assign empty    = (depth_q == '0);
    assign depth    = depth_q;
    assign top_prio = empty ? '0 : prio_q[top_ptr[IDX_W-1:0]];
    assign top_src  = empty ? '0 : src_q[top_ptr[IDX_W-1:0]];

    // Push onto or pop from the entry stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                prio_q[k] <= '0;
                src_q[k]  <= '0;
            end
        end else if (push && depth_q != CNT_W'(DEPTH)) begin
            prio_q[depth_q[IDX_W-1:0]] <= push_prio;
            src_q[depth_q[IDX_W-1:0]]  <= push_src;
            depth_q                    <= depth_q + CNT_W'(1);
        end else if (pop && !empty) begin
            depth_q <= top_ptr;
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the vectored interrupt controller: decodes the register bus,
// holds the selection and spurious vector, and joins the source bank, the
// arbiter and the nesting stack. Assumes a single-cycle bus; a write wins
// over a read in the same cycle.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);
    localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [SRC_W-1:0]          sel_q;
    logic [DATA_W-1:0]         spur_q;
    logic                      rd_act;
    logic                      ack;
    logic                      eoi;
    src_mode_t                 sel_mode;
    logic [DATA_W-1:0]         sel_vec;
    logic                      sel_en;
    logic [DATA_W-1:0]         win_vec;
    logic [NUM_SRC-1:0]        req;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      win_valid;
    logic [SRC_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;
    logic [CNT_W-1:0]          stk_depth;
    logic                      stk_empty;
    logic [PRIO_W-1:0]         top_prio;
    logic [SRC_W-1:0]          top_src;
    logic [DATA_W-1:0]         rd_mux;

    assign rd_act  = rd_en & ~wr_en;
    assign irq_out = win_valid & (stk_empty | (win_prio > top_prio));
    assign ack     = rd_act & (addr == OFS_ACK) & irq_out;
    assign eoi     = wr_en & (addr == OFS_EOI);

    // Selection and spurious vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            spur_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_SEL)  sel_q  <= wdata[SRC_W-1:0];
            if (addr == OFS_SPUR) spur_q <= wdata;
        end
    end

    ivc_src_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .sel       (sel_q),
        .mode_we   (wr_en && addr == OFS_MODE),
        .vec_we    (wr_en && addr == OFS_VEC),
        .ena_cmd   (wr_en && addr == OFS_ENA),
        .dis_cmd   (wr_en && addr == OFS_DIS),
        .clr_cmd   (wr_en && addr == OFS_CLR),
        .set_cmd   (wr_en && addr == OFS_SET),
        .wdata     (wdata),
        .ack       (ack),
        .ack_idx   (win_idx),
        .win_idx   (win_idx),
        .sel_mode  (sel_mode),
        .sel_vec   (sel_vec),
        .sel_en    (sel_en),
        .win_vec   (win_vec),
        .req       (req),
        .prio_flat (prio_flat)
    );

    ivc_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .req       (req),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    ivc_nest_stack #(.DEPTH(DEPTH), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack),
        .push_prio (win_prio),
        .push_src  (win_idx),
        .pop       (eoi),
        .depth     (stk_depth),
        .empty     (stk_empty),
        .top_prio  (top_prio),
        .top_src   (top_src)
    );

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        case (addr)
            OFS_SEL:  rd_mux[SRC_W-1:0] = sel_q;
            OFS_MODE: begin
                rd_mux[PRIO_LSB +: PRIO_W] = sel_mode.prio;
                rd_mux[TRIG_LSB +: 2]      = sel_mode.trig;
            end
            OFS_VEC:  rd_mux = sel_vec;
            OFS_ACK:  rd_mux = irq_out ? win_vec : spur_q;
            OFS_CUR:  rd_mux[SRC_W-1:0] = top_src;
            OFS_MASK: rd_mux[0] = sel_en;
            OFS_SPUR: rd_mux = spur_q;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_act) rd_data <= rd_mux;
    end
endmodule

// File: rtl/ivc_chk.sv
// Property checker for irq_vector_ctrl, attached through bind.
module ivc_chk
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned SRC_W   = 7,
    parameter int unsigned CNT_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               wr_en,
    input logic               rd_en,
    input logic [DATA_W-1:0]  rd_data,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] req,
    input logic [SRC_W-1:0]   win_idx,
    input logic [DATA_W-1:0]  spur_q,
    input logic [CNT_W-1:0]   stk_depth,
    input logic               stk_empty,
    input logic [PRIO_W-1:0]  top_prio,
    input logic [SRC_W-1:0]   top_src
);
    logic ack_rd;
    logic miss_rd;
    logic eoi_wr;

    assign ack_rd  = rd_en && !wr_en && addr == OFS_ACK && irq_out;
    assign miss_rd = rd_en && !wr_en && addr == OFS_ACK && !irq_out;
    assign eoi_wr  = wr_en && addr == OFS_EOI;

    // R7
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> (stk_depth == $past(stk_depth) + CNT_W'(1)) && (top_src == $past(win_idx)));

    // R8
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_rd |=> (rd_data == $past(spur_q)) && $stable(stk_depth));

    // R9
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !stk_empty) |=> stk_depth == $past(stk_depth) - CNT_W'(1));

    // R9
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && stk_empty) |=> stk_empty);

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= CNT_W'(DEPTH));

    // R6
    top7_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stk_empty && top_prio == '1) |-> !irq_out);

    // R6
    irq_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (req != '0));
endmodule

bind irq_vector_ctrl ivc_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .DEPTH(DEPTH), .SRC_W(SRC_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .irq_out   (irq_out),
    .req       (req),
    .win_idx   (win_idx),
    .spur_q    (spur_q),
    .stk_depth (stk_depth),
    .stk_empty (stk_empty),
    .top_prio  (top_prio),
    .top_src   (top_src)
);

// File: tb/irq_vector_ctrl_bench.sv
// Self-checking bench: 16 sources, expected values computed from the
// requirements. 50 MHz clock (20 time-unit period).
module irq_vector_ctrl_bench;
    localparam int NS = 16;
    localparam int DW = 32;

    localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08,
        A_ACK = 8'h10, A_CUR = 8'h18, A_MASK = 8'h30, A_EOI = 8'h38,
        A_SPUR = 8'h3C, A_ENA = 8'h40, A_DIS = 8'h44, A_CLR = 8'h48,
        A_SET = 8'h4C, A_DBG = 8'h6C;
    localparam logic [31:0] SPUR_V = 32'h5A5A_0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [NS-1:0] irq_src = '0;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] vexp [NS];
    logic [2:0]  pexp [NS];

    always #10 clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .DEPTH(8)) u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rd_data(rd_data), .irq_src(irq_src), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic cmd(input int idx, input logic [7:0] a);
        bus_wr(A_SEL, 32'(idx));
        bus_wr(a, 32'd1);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        chk(tag, {31'b0, irq_out}, {31'b0, exp});
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    function automatic int winner(input logic [NS-1:0] m);
        int w = -1;
        for (int i = 0; i < NS; i++)
            if (m[i] && (w < 0 || pexp[i] > pexp[w])) w = i;
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [NS-1:0] m;
        int seq [8];
        seq = '{0, 3, 6, 1, 4, 7, 2, 5};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk_irq("R11 irq after reset", 1'b0);
        bus_rd(A_SEL, d);  chk("R11 select reset", d, 32'd0);
        bus_rd(A_MODE, d); chk("R11 mode reset", d, 32'd0);
        bus_rd(A_VEC, d);  chk("R11 vector reset", d, 32'd0);
        bus_rd(A_SPUR, d); chk("R11 spurious reset", d, 32'd0);
        bus_rd(A_ACK, d);  chk("R11 ack reads spurious 0", d, 32'd0);
        bus_rd(A_CUR, d);  chk("R11 current reset", d, 32'd0);

        // R1 R2 program all sources, junk in bits 3,4,7+ of mode
        for (int i = 0; i < NS; i++) begin
            vexp[i] = 32'hC0DE_0000 + 32'(i) * 32'h111;
            pexp[i] = 3'((i * 3) % 8);
            bus_wr(A_SEL, 32'(i));
            bus_wr(A_VEC, vexp[i]);
            bus_wr(A_MODE, 32'hFFFF_FF98 | 32'(pexp[i]));
        end
        for (int i = 0; i < NS; i++) begin
            bus_wr(A_SEL, 32'(i));
            bus_rd(A_SEL, d);  chk("R1 select readback", d, 32'(i));
            bus_rd(A_VEC, d);  chk("R1 vector readback", d, vexp[i]);
            bus_rd(A_MODE, d); chk("R2 mode readback", d, 32'(pexp[i]));
        end

        // R12 read data holds between reads
        bus_rd(A_VEC, d);
        bus_wr(A_SEL, 32'd2);
        bus_wr(A_SPUR, SPUR_V);
        chk("R12 rd_data held", rd_data, vexp[NS-1]);

        // R3 enable even sources, mask status sweep
        for (int i = 0; i < NS; i += 2) cmd(i, A_ENA);
        for (int i = 0; i < NS; i++) begin
            bus_wr(A_SEL, 32'(i));
            bus_rd(A_MASK, d);
            chk("R3 mask status", d, (i % 2 == 0) ? 32'd1 : 32'd0);
        end
        for (int i = 1; i < NS; i += 2) cmd(i, A_ENA);
        chk_irq("R3 no pending", 1'b0);

        // R5 R7 arbitration drain sweep
        for (int t = 0; t < 12; t++) begin
            m = NS'(t * 40503 + 7) | (NS'(1) << t);
            for (int i = 0; i < NS; i++) if (m[i]) cmd(i, A_SET);
            while (m != '0) begin
                int w;
                w = winner(m);
                chk_irq("R6 irq with empty stack", 1'b1);
                bus_rd(A_ACK, d); chk("R5 winner vector", d, vexp[w]);
                bus_rd(A_CUR, d); chk("R7 current source", d, 32'(w));
                bus_wr(A_EOI, 32'd0);
                m[w] = 1'b0;
            end
            chk_irq("R7 ack cleared latches", 1'b0);
        end

        // R6 R8 R9 nesting
        cmd(1, A_SET);
        chk_irq("R6 p3 on empty", 1'b1);
        bus_rd(A_ACK, d); chk("R7 ack src1", d, vexp[1]);
        chk_irq("R6 in service", 1'b0);
        cmd(9, A_SET);
        chk_irq("R6 equal priority blocked", 1'b0);
        bus_rd(A_ACK, d); chk("R8 spurious vector", d, SPUR_V);
        bus_rd(A_CUR, d); chk("R8 no push on spurious", d, 32'd1);
        cmd(2, A_SET);
        chk_irq("R6 higher priority", 1'b1);
        bus_rd(A_ACK, d); chk("R7 ack src2", d, vexp[2]);
        bus_rd(A_CUR, d); chk("R7 current src2", d, 32'd2);
        cmd(5, A_SET);
        bus_rd(A_ACK, d); chk("R7 ack src5", d, vexp[5]);
        bus_rd(A_CUR, d); chk("R7 current src5", d, 32'd5);
        chk_irq("R6 top priority 7", 1'b0);
        bus_wr(A_EOI, 32'd0);
        bus_rd(A_CUR, d); chk("R9 pop to src2", d, 32'd2);
        chk_irq("R6 p3 under p6", 1'b0);
        bus_wr(A_EOI, 32'd0);
        bus_rd(A_CUR, d); chk("R9 pop to src1", d, 32'd1);
        chk_irq("R6 p3 under p3", 1'b0);
        bus_wr(A_EOI, 32'd0);
        bus_rd(A_CUR, d); chk("R9 stack empty", d, 32'd0);
        chk_irq("R6 src9 released", 1'b1);
        bus_rd(A_ACK, d); chk("R7 ack src9", d, vexp[9]);
        bus_wr(A_EOI, 32'd0);
        bus_wr(A_EOI, 32'd0);
        chk_irq("R9 empty eoi idle", 1'b0);
        cmd(1, A_SET);
        bus_wr(A_EOI, 32'd0);
        chk_irq("R9 empty eoi keeps request", 1'b1);
        bus_rd(A_ACK, d); chk("R9 push after empty eoi", d, vexp[1]);
        bus_wr(A_EOI, 32'd0);

        // R9 full eight-level stack
        foreach (seq[k]) begin
            cmd(seq[k], A_SET);
            bus_rd(A_ACK, d); chk("R9 fill level", d, vexp[seq[k]]);
        end
        cmd(8, A_SET);
        chk_irq("R6 stack at 7 blocks p0", 1'b0);
        for (int k = 1; k <= 8; k++) begin
            bus_wr(A_EOI, 32'd0);
            bus_rd(A_CUR, d);
            chk("R9 unwind", d, (k < 8) ? 32'(seq[8-k-1]) : 32'd0);
        end
        chk_irq("R9 released after 8", 1'b1);
        bus_wr(A_EOI, 32'd0);
        chk_irq("R9 ninth eoi no effect", 1'b1);
        bus_rd(A_ACK, d); chk("R9 ack src8", d, vexp[8]);
        bus_wr(A_EOI, 32'd0);

        // R4 trigger types, one source enabled at a time
        for (int i = 0; i < NS; i++) cmd(i, A_DIS);
        bus_wr(A_SEL, 32'd5);
        bus_rd(A_MASK, d); chk("R3 disabled mask", d, 32'd0);
        // level-high on src4
        cmd(4, A_ENA);
        irq_src[4] = 1'b1; settle();
        chk_irq("R4 level-high active", 1'b1);
        bus_rd(A_ACK, d); chk("R4 ack src4", d, vexp[4]);
        bus_wr(A_EOI, 32'd0);
        chk_irq("R4 level persists", 1'b1);
        irq_src[4] = 1'b0; settle();
        chk_irq("R4 level-high released", 1'b0);
        cmd(4, A_DIS);
        // rising edge on src5
        bus_wr(A_SEL, 32'd5);
        bus_wr(A_MODE, (32'd1 << 5) | 32'(pexp[5]));
        bus_wr(A_ENA, 32'd1);
        irq_src[5] = 1'b1; settle();
        irq_src[5] = 1'b0; settle();
        chk_irq("R4 rising latched", 1'b1);
        bus_rd(A_ACK, d); chk("R4 ack src5", d, vexp[5]);
        bus_wr(A_EOI, 32'd0);
        chk_irq("R4 rising cleared by ack", 1'b0);
        irq_src[5] = 1'b1; settle();
        chk_irq("R4 second rise", 1'b1);
        bus_wr(A_CLR, 32'd1);
        chk_irq("R3 clear with line high", 1'b0);
        irq_src[5] = 1'b0;
        bus_wr(A_DIS, 32'd1);
        // level-low on src6
        irq_src[6] = 1'b1;
        bus_wr(A_SEL, 32'd6);
        bus_wr(A_MODE, (32'd2 << 5) | 32'(pexp[6]));
        bus_wr(A_ENA, 32'd1);
        chk_irq("R4 level-low idle", 1'b0);
        irq_src[6] = 1'b0; settle();
        chk_irq("R4 level-low active", 1'b1);
        irq_src[6] = 1'b1; settle();
        chk_irq("R4 level-low released", 1'b0);
        bus_wr(A_DIS, 32'd1);
        // falling edge on src7
        irq_src[7] = 1'b1;
        bus_wr(A_SEL, 32'd7);
        bus_wr(A_MODE, (32'd3 << 5) | 32'(pexp[7]));
        bus_rd(A_MODE, d); chk("R2 falling mode readback", d, 32'h60 | 32'(pexp[7]));
        bus_wr(A_ENA, 32'd1);
        chk_irq("R4 falling idle high", 1'b0);
        irq_src[7] = 1'b0; settle();
        chk_irq("R4 falling latched", 1'b1);
        irq_src[7] = 1'b1; settle();
        chk_irq("R4 falling held", 1'b1);
        bus_wr(A_CLR, 32'd1);
        chk_irq("R3 clear falling", 1'b0);
        bus_wr(A_DIS, 32'd1);
        irq_src[7] = 1'b0; settle();
        chk_irq("R3 disabled pending quiet", 1'b0);
        bus_wr(A_ENA, 32'd1);
        chk_irq("R3 pending kept while disabled", 1'b1);
        bus_wr(A_CLR, 32'd1);
        chk_irq("R3 clear after enable", 1'b0);

        // R10 debug register has no effect
        bus_wr(A_SEL, 32'd3);
        bus_wr(A_DBG, 32'hFFFF_FFFF);
        bus_rd(A_DBG, d);  chk("R10 debug reads 0", d, 32'd0);
        bus_rd(A_SEL, d);  chk("R10 select kept", d, 32'd3);
        bus_rd(A_MODE, d); chk("R10 mode kept", d, 32'(pexp[3]));
        bus_rd(A_MASK, d); chk("R10 enable kept", d, 32'd0);
        chk_irq("R10 irq kept", 1'b0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule